// File: doc/BRIEF.md
# Immediate-Capable ALU with Condition-Code Flags

A 16-bit arithmetic/logic unit for a small load/store processor datapath. Each cycle it combines a first register operand with a second operand and produces a result. The second operand is either a second register value or a 5-bit immediate field of the instruction word, sign-extended to the data width. The operations are addition, bitwise AND, bitwise complement of the first operand, and a pass-through of the first operand. Stores use the pass-through to place register data on the shared bus.

The block also holds the processor's three condition flags: negative, zero and positive. Whenever the register write enable is asserted, the value being written to the register file is classified, and the flag register takes that class on the next clock edge. This includes values that arrive from memory as well as ALU results. Exactly one flag is set at all times.

The block receives the low six bits of the instruction word. Bit 5 selects immediate mode, bits 4:0 carry the immediate, and bits 2:0 name the second source register. That register index is passed out to the register file. The register file and the bus gating sit outside the block.

Top module: `imm_alu_cc`

## Requirements
- R1: With op_sel = 2'b00 (add) and ir_field[5] = 0, result equals (src1 + src2) modulo 2^16, and the same cycle (combinational).
- R2: With ir_field[5] = 1, the second operand is ir_field[4:0] sign-extended to 16 bits (bit 4 copied to bits 15:5). src2 has no effect on result in this mode.
- R3: With op_sel = 2'b01 (and), result equals src1 bitwise-AND the second operand chosen as in R1/R2.
- R4: With op_sel = 2'b10 (not), result equals the bitwise complement of src1, whatever src2 and ir_field hold.
- R5: With op_sel = 2'b11 (pass), result equals src1 unchanged, whatever src2 and ir_field hold.
- R6: src2_idx always equals ir_field[2:0].
- R7: While rst_n is low, flags = 3'b010 (bit 2 negative, bit 1 zero, bit 0 positive).
- R8: When reg_we is 1 at a clock edge outside reset, flags after that edge are 3'b100 if wr_data[15] is 1, 3'b010 if wr_data is zero, and 3'b001 otherwise.
- R9: When reg_we is 0 at a clock edge, flags keep their value.
- R10: Exactly one bit of flags is 1 in every cycle.
- R11: Reset is asserted at once and released through a two-stage synchronizer. Writes at the first two clock edges after rst_n rises are ignored (flags stay 3'b010), and the write at the third edge takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src1 | input | 16 | First register operand |
| src2 | input | 16 | Second register operand |
| ir_field | input | 6 | Instruction bits 5:0 (mode bit, immediate, register index) |
| op_sel | input | 2 | Operation: 00 add, 01 and, 10 not, 11 pass |
| reg_we | input | 1 | Register write enable; gates the flag update |
| wr_data | input | 16 | Value written to the register file, classified for the flags |
| result | output | 16 | ALU result |
| src2_idx | output | 3 | Second source register index |
| flags | output | 3 | Condition flags {negative, zero, positive} |

## Verification
On every cycle, the assertions check the arithmetic relation of result to the operands for each operation and mode, that the flags are one-hot, that the flags hold when no write occurs, and that a write records the class of its value. Only the bench scenarios can show that src2 is truly ignored in immediate mode across all 32 immediates. They also show that the reset-release window swallows exactly two writes, and that negative, zero and positive boundary values (0x0000, 0x0001, 0x7FFF, 0x8000, 0xFFFF) fall into the right class.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_AND  = 2'b01,
    OP_NOT  = 2'b10,
    OP_PASS = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } cc_t;

  localparam cc_t CC_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};
endpackage

// File: rtl/imm_alu_rst_sync.sv
module imm_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/imm_alu_opnd_b.sv
module imm_alu_opnd_b #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 5
) (
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm_raw,
  input  logic              use_imm,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int EXT_W = DATA_W - IMM_W;
  logic [DATA_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      always_comb imm_ext = {{EXT_W{imm_raw[IMM_W-1]}}, imm_raw};
    end else begin : g_noext
      always_comb imm_ext = imm_raw[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    opnd_b = use_imm ? imm_ext : reg_val;
  end
endmodule

// File: rtl/imm_alu_core.sv
module imm_alu_core
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] sum_v;
  logic [DATA_W-1:0] and_v;
  logic [DATA_W-1:0] inv_v;

  always_comb begin
    sum_v = a + b;
    and_v = a & b;
    inv_v = ~a;
    unique case (op)
      OP_ADD:  y = sum_v;
      OP_AND:  y = and_v;
      OP_NOT:  y = inv_v;
      OP_PASS: y = a;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/imm_alu_cc_reg.sv
module imm_alu_cc_reg
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] value,
  output cc_t               cc
);
  cc_t cc_class;
  cc_t cc_d;
  cc_t cc_q;

  always_comb begin
    cc_class.neg  = value[DATA_W-1];
    cc_class.zero = (value == '0);
    cc_class.pos  = !value[DATA_W-1] && (value != '0);
  end

  always_comb begin
    cc_d = cc_q;
    if (we) cc_d = cc_class;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_q <= CC_RESET;
    else        cc_q <= cc_d;
  end

  assign cc = cc_q;
endmodule

// File: rtl/imm_alu_cc.sv
module imm_alu_cc
  import imm_alu_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int IMM_W       = 5,
  parameter int IDX_W       = 3,
  parameter int MODE_BIT    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   src1,
  input  logic [DATA_W-1:0]   src2,
  input  logic [MODE_BIT:0]   ir_field,
  input  logic [1:0]          op_sel,
  input  logic                reg_we,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   result,
  output logic [IDX_W-1:0]    src2_idx,
  output logic [2:0]          flags
);
  logic              rst_n_int;
  logic [DATA_W-1:0] opnd_b;
  cc_t               cc;

  imm_alu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  imm_alu_opnd_b #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opb (
    .reg_val(src2), .imm_raw(ir_field[IMM_W-1:0]),
    .use_imm(ir_field[MODE_BIT]), .opnd_b(opnd_b)
  );

  imm_alu_core #(.DATA_W(DATA_W)) u_core (
    .op(alu_op_e'(op_sel)), .a(src1), .b(opnd_b), .y(result)
  );

  imm_alu_cc_reg #(.DATA_W(DATA_W)) u_cc (
    .clk(clk), .rst_n(rst_n_int), .we(reg_we), .value(wr_data), .cc(cc)
  );

  assign src2_idx = ir_field[IDX_W-1:0];
  assign flags    = cc;
endmodule

// File: rtl/imm_alu_cc_chk.sv
module imm_alu_cc_chk #(
  parameter int DATA_W   = 16,
  parameter int MODE_BIT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_n_int,
  input logic [DATA_W-1:0] src1,
  input logic [DATA_W-1:0] src2,
  input logic [MODE_BIT:0] ir_field,
  input logic [1:0]        op_sel,
  input logic              reg_we,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] result,
  input logic [2:0]        flags
);
  logic [DATA_W-1:0] imm_x;
  assign imm_x = {{(DATA_W-MODE_BIT){ir_field[MODE_BIT-1]}}, ir_field[MODE_BIT-1:0]};

  // R1
  add_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b00 && !ir_field[MODE_BIT]) |-> result == DATA_W'(src1 + src2));
  // R2
  add_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b00 && ir_field[MODE_BIT]) |-> result == DATA_W'(src1 + imm_x));
  // R3
  and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 2'b01 |-> result == (src1 & (ir_field[MODE_BIT] ? imm_x : src2)));
  // R4
  not_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 2'b10 |-> result == ~src1);
  // R5
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 2'b11 |-> result == src1);
  // R10
  onehot_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags) == 1);
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !reg_we |=> $stable(flags));
  // R8
  flag_neg_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (reg_we && wr_data[DATA_W-1]) |=> flags == 3'b100);
  // R8
  flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (reg_we && wr_data == '0) |=> flags == 3'b010);
  // R8
  flag_pos_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (reg_we && !wr_data[DATA_W-1] && wr_data != '0) |=> flags == 3'b001);
  // R11
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_n_int |=> flags == 3'b010);
endmodule

bind imm_alu_cc imm_alu_cc_chk #(.DATA_W(DATA_W), .MODE_BIT(MODE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_n_int(rst_n_int), .src1(src1), .src2(src2),
  .ir_field(ir_field), .op_sel(op_sel), .reg_we(reg_we), .wr_data(wr_data),
  .result(result), .flags(flags)
);

// File: tb/sim_imm_alu_cc.sv
module sim_imm_alu_cc;
  logic        clk;
  logic        rst_n;
  logic [15:0] src1, src2, wr_data, result;
  logic [5:0]  ir_field;
  logic [1:0]  op_sel;
  logic        reg_we;
  logic [2:0]  src2_idx, flags;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  imm_alu_cc u0 (
    .clk(clk), .rst_n(rst_n), .src1(src1), .src2(src2), .ir_field(ir_field),
    .op_sel(op_sel), .reg_we(reg_we), .wr_data(wr_data), .result(result),
    .src2_idx(src2_idx), .flags(flags)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] classify(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  function automatic logic [15:0] model(input logic [1:0] op, input logic [15:0] a,
                                        input logic [15:0] r2, input logic [5:0] ir);
    logic [15:0] b;
    b = ir[5] ? {{11{ir[4]}}, ir[4:0]} : r2;
    case (op)
      2'b00: return a + b;
      2'b01: return a & b;
      2'b10: return ~a;
      default: return a;
    endcase
  endfunction

  task automatic flag_write(input logic [15:0] v, input logic [2:0] exp, input string req);
    @(negedge clk);
    reg_we = 1; wr_data = v;
    @(negedge clk);
    reg_we = 0;
    chk(flags == exp, req, {13'h0, flags}, {13'h0, exp});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] a_list [8];
    logic [2:0]  held;
    a_list = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hA5A5, 16'h00F0};
    lfsr = 16'hACE1;
    rst_n = 0; src1 = 0; src2 = 0; ir_field = 0; op_sel = 0; reg_we = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    // R7: reset state, even with a write request pending
    reg_we = 1; wr_data = 16'h8000;
    @(negedge clk);
    chk(flags == 3'b010, "R7 reset flags", {13'h0, flags}, 16'h2);
    // R11: two edges after release are ignored, third takes effect
    rst_n = 1;
    @(negedge clk);
    chk(flags == 3'b010, "R11 edge1 ignored", {13'h0, flags}, 16'h2);
    @(negedge clk);
    chk(flags == 3'b010, "R11 edge2 ignored", {13'h0, flags}, 16'h2);
    @(negedge clk);
    chk(flags == 3'b100, "R11 edge3 write", {13'h0, flags}, 16'h4);
    reg_we = 0;

    // R1..R6 sweep: every op, both modes, all 32 immediate/index patterns
    for (int op = 0; op < 4; op++) begin
      for (int md = 0; md < 2; md++) begin
        for (int im = 0; im < 32; im++) begin
          for (int k = 0; k < 8; k++) begin
            logic [15:0] exp;
            string tag;
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op_sel = op[1:0]; ir_field = {md[0], im[4:0]};
            src1 = a_list[k]; src2 = lfsr;
            #2;
            exp = model(op_sel, src1, src2, ir_field);
            case (op)
              0: tag = md ? "R2 add imm" : "R1 add reg";
              1: tag = md ? "R2/R3 and imm" : "R3 and reg";
              2: tag = "R4 not";
              default: tag = "R5 pass";
            endcase
            chk(result == exp, tag, result, exp);
            chk(src2_idx == im[2:0], "R6 index", {13'h0, src2_idx}, {13'h0, im[2:0]});
            // R2: changing src2 in immediate mode has no effect
            if (md == 1 || op >= 2) begin
              src2 = ~src2;
              #2;
              chk(result == exp, "R2/R4/R5 src2 ignored", result, exp);
            end
          end
        end
      end
    end

    // R8 boundary classes, R10 one-hot
    flag_write(16'h0000, 3'b010, "R8 zero");
    flag_write(16'h0001, 3'b001, "R8 +1");
    flag_write(16'h7FFF, 3'b001, "R8 max pos");
    flag_write(16'h8000, 3'b100, "R8 min neg");
    flag_write(16'hFFFF, 3'b100, "R8 -1");
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      flag_write(lfsr, classify(lfsr), "R8 sweep");
      chk($countones(flags) == 1, "R10 one-hot", {13'h0, flags}, 16'h0);
      // R9: no write -> hold, even with a different value presented
      held = flags;
      @(negedge clk);
      wr_data = ~lfsr; reg_we = 0;
      @(negedge clk);
      chk(flags == held, "R9 hold", {13'h0, flags}, {13'h0, held});
    end

    // R7 again: mid-run asynchronous reset
    @(negedge clk);
    rst_n = 0;
    #1;
    chk(flags == 3'b010, "R7 async reset", {13'h0, flags}, 16'h2);
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule